// File: doc/BRIEF.md
# Wrapping Stack Pointer and Interrupt Context Sequencer

This block holds the stack pointer of a small 8-bit processor and walks through the byte-by-byte pushes and pops for every stack operation. The stack lives in a fixed 128-byte window, 0180h to 01FFh. Only the low seven bits of the pointer are stored, so the pointer cannot leave that window. It wraps without any warning in both directions. The pointer always names the next free byte. A push writes at the pointer and then moves it down. A pop first moves the pointer up and then reads at the new address.

An instruction decoder raises one strobe per command: call, return, single push, single pop, interrupt entry, interrupt return, pointer reset, or load of the pointer's low byte. The operands (program counter, X, A, condition code, push byte) are captured in the cycle the command is accepted. After that the block drives one memory access per clock. Multi-byte sequences keep `busy` high until the last byte has been moved. Restored values appear on the output registers once the matching pop has been done. If several strobes arrive in the same idle cycle, the order of precedence is: pointer reset, low-byte load, interrupt entry, interrupt return, call, return, push, pop.

Top module: `stk_ctx_unit`

## Requirements
- R1: After reset, and one clock after an accepted pointer-reset strobe, `sp` reads 01FFh.
- R2: Bits 15..7 of `sp` are always 000000011b, so `sp` stays between 0180h and 01FFh.
- R3: A push writes `mem_wdata` at address `sp` and then decrements `sp`. A pop drives `mem_addr` = `sp`+1 (wrapped), takes `mem_rdata` in that cycle, and increments `sp`.
- R4: Decrementing from 0180h gives 01FFh, and incrementing from 01FFh gives 0180h, with no other effect.
- R5: A call writes the PC low byte at the first address and the PC high byte at the next lower one, leaving `sp` two lower. A return pops the high byte and then the low byte into `pc_out`.
- R6: Interrupt entry writes five bytes at descending addresses in this order: PC low, PC high, X, A, condition code. Y is not saved, and `sp` ends five lower.
- R7: The condition-code byte stored on interrupt entry has bit 3 (the interrupt mask) set. Interrupt return pops condition code, A, X, PC high, PC low, and `cc_out` equals the stored byte, so the mask bit comes from memory.
- R8: A load-low strobe sets `sp` to {000000011b, `ld_val[6:0]`}.
- R9: Each transferred byte takes one clock. `busy` stays high for 1 cycle for push and pop, 2 for call and return, and 5 for interrupt entry and return. `mem_we` is low whenever `busy` is low.
- R10: Any strobe raised while `busy` is high is ignored. The running sequence finishes unchanged, and neither memory nor `sp` is touched by the ignored command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| do_call | input | 1 | Start subroutine-call push (2 bytes) |
| do_ret | input | 1 | Start subroutine-return pop (2 bytes) |
| do_push | input | 1 | Push `push_in` |
| do_pop | input | 1 | Pop one byte into `pop_out` |
| do_irq | input | 1 | Start interrupt context save (5 bytes) |
| do_iret | input | 1 | Start interrupt context restore (5 bytes) |
| do_sprst | input | 1 | Reset pointer to 01FFh |
| do_spld | input | 1 | Load pointer low bits from `ld_val` |
| ld_val | input | 8 | Value for the low-byte load |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition code to save |
| push_in | input | 8 | Byte for a single push |
| mem_rdata | input | 8 | Memory read data for the current `mem_addr` |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Write enable |
| busy | output | 1 | A sequence is in progress |
| sp | output | 16 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored X |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition code |
| pop_out | output | 8 | Byte from the last single pop |

## Verification
The bench uses the default parameters: a 16-bit pointer, a 7-bit window index, an 01FFh stack top, and bit 3 as the mask bit. With a 128-byte window a single low-byte load can put the pointer at the bottom boundary. One push and one pop then cover both wrap directions in a few cycles. The five-byte interrupt frame fits in a bench memory of 512 bytes, so every frame byte and every untouched neighbouring byte can be inspected directly.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    K_IDLE, K_PUSH, K_POP, K_CALL, K_RET, K_IRQ, K_IRET
  } kind_e;

  typedef enum logic [2:0] {
    D_NONE, D_PCL, D_PCH, D_X, D_A, D_CC, D_POP
  } dest_e;

  localparam int unsigned CALL_BYTES = 2;
  localparam int unsigned CTX_BYTES  = 5;

  function automatic logic [2:0] last_step(kind_e k);
    case (k)
      K_CALL, K_RET: last_step = 3'(CALL_BYTES - 1);
      K_IRQ, K_IRET: last_step = 3'(CTX_BYTES - 1);
      default:       last_step = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned SP_W      = 16,
  parameter int unsigned WIN_W     = 7,
  parameter int unsigned DATA_W    = 8,
  parameter logic [15:0] STACK_TOP = 16'h01FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_rst,
  input  logic              p_ld,
  input  logic              p_dec,
  input  logic              p_inc,
  input  logic [DATA_W-1:0] ld_val,
  output logic [SP_W-1:0]   sp,
  output logic [SP_W-1:0]   sp_up
);
  localparam logic [SP_W-WIN_W-1:0] HI_BITS  = STACK_TOP[SP_W-1:WIN_W];
  localparam logic [WIN_W-1:0]      LOW_INIT = STACK_TOP[WIN_W-1:0];

  logic [WIN_W-1:0] low_q, low_d;

  always_comb begin
    low_d = low_q;
    if (p_rst)      low_d = LOW_INIT;
    else if (p_ld)  low_d = WIN_W'(ld_val);
    else if (p_dec) low_d = low_q - 1'b1;
    else if (p_inc) low_d = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= LOW_INIT;
    else        low_q <= low_d;
  end

  assign sp    = {HI_BITS, low_q};
  assign sp_up = {HI_BITS, low_q + 1'b1};

  p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_dec && !p_rst && !p_ld && low_q == '0) |=> (low_q == '1));
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_inc && !p_dec && !p_rst && !p_ld && low_q == '1) |=> (low_q == '0));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned IMASK_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_call,
  input  logic              do_ret,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic              do_irq,
  input  logic              do_iret,
  input  logic              do_sprst,
  input  logic              do_spld,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] cc_in,
  input  logic [DATA_W-1:0] push_in,
  output logic              busy,
  output logic              wr,
  output logic              rd,
  output logic [DATA_W-1:0] wdata,
  output dest_e             dest,
  output logic              p_rst,
  output logic              p_ld
);
  kind_e            kind_q, kind_d;
  logic [2:0]       step_q, step_d;
  logic             cap;
  logic [PC_W-1:0]  pc_q;
  logic [DATA_W-1:0] x_q, a_q, cc_q, byte_q;
  logic             any_cmd;

  assign busy    = (kind_q != K_IDLE);
  assign any_cmd = do_call | do_ret | do_push | do_pop | do_irq | do_iret
                 | do_sprst | do_spld;

  // next state
  always_comb begin
    kind_d = kind_q;
    step_d = step_q;
    cap    = 1'b0;
    p_rst  = 1'b0;
    p_ld   = 1'b0;
    if (!busy) begin
      step_d = 3'd0;
      if (do_sprst)     p_rst  = 1'b1;
      else if (do_spld) p_ld   = 1'b1;
      else if (do_irq)  begin kind_d = K_IRQ;  cap = 1'b1; end
      else if (do_iret) kind_d = K_IRET;
      else if (do_call) begin kind_d = K_CALL; cap = 1'b1; end
      else if (do_ret)  kind_d = K_RET;
      else if (do_push) begin kind_d = K_PUSH; cap = 1'b1; end
      else if (do_pop)  kind_d = K_POP;
    end else if (step_q == last_step(kind_q)) begin
      kind_d = K_IDLE;
      step_d = 3'd0;
    end else begin
      step_d = step_q + 3'd1;
    end
  end

  // state and operand registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IDLE;
      step_q <= 3'd0;
    end else begin
      kind_q <= kind_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      x_q    <= '0;
      a_q    <= '0;
      cc_q   <= '0;
      byte_q <= '0;
    end else if (cap) begin
      pc_q   <= pc_in;
      x_q    <= x_in;
      a_q    <= a_in;
      cc_q   <= cc_in | (DATA_W'(1) << IMASK_BIT);
      byte_q <= push_in;
    end
  end

  // byte selection per step
  always_comb begin
    wr    = 1'b0;
    rd    = 1'b0;
    wdata = '0;
    dest  = D_NONE;
    case (kind_q)
      K_PUSH: begin wr = 1'b1; wdata = byte_q; end
      K_CALL: begin
        wr    = 1'b1;
        wdata = (step_q == 3'd0) ? pc_q[DATA_W-1:0] : pc_q[PC_W-1:DATA_W];
      end
      K_IRQ: begin
        wr = 1'b1;
        case (step_q)
          3'd0:    wdata = pc_q[DATA_W-1:0];
          3'd1:    wdata = pc_q[PC_W-1:DATA_W];
          3'd2:    wdata = x_q;
          3'd3:    wdata = a_q;
          default: wdata = cc_q;
        endcase
      end
      K_POP: begin rd = 1'b1; dest = D_POP; end
      K_RET: begin rd = 1'b1; dest = (step_q == 3'd0) ? D_PCH : D_PCL; end
      K_IRET: begin
        rd = 1'b1;
        case (step_q)
          3'd0:    dest = D_CC;
          3'd1:    dest = D_A;
          3'd2:    dest = D_X;
          3'd3:    dest = D_PCH;
          default: dest = D_PCL;
        endcase
      end
      default: ;
    endcase
  end

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_cmd && step_q != last_step(kind_q)) |=> $stable(kind_q));
  p_ctx_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_IRQ || kind_q == K_IRET) |-> (step_q < 3'(CTX_BYTES)));
  p_mask_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind_q == K_IRQ && step_q == 3'd4) |-> wdata[IMASK_BIT]);
endmodule

// File: rtl/stk_restore.sv
module stk_restore
  import stk_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  dest_e             dest,
  input  logic [DATA_W-1:0] rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] cc_out,
  output logic [DATA_W-1:0] pop_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out  <= '0;
      x_out   <= '0;
      a_out   <= '0;
      cc_out  <= '0;
      pop_out <= '0;
    end else if (rd) begin
      case (dest)
        D_PCL: pc_out[DATA_W-1:0]    <= rdata;
        D_PCH: pc_out[PC_W-1:DATA_W] <= rdata;
        D_X:   x_out   <= rdata;
        D_A:   a_out   <= rdata;
        D_CC:  cc_out  <= rdata;
        D_POP: pop_out <= rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_ctx_unit.sv
module stk_ctx_unit
  import stk_pkg::*;
#(
  parameter int unsigned SP_W      = 16,
  parameter int unsigned WIN_W     = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned IMASK_BIT = 3,
  parameter logic [15:0] STACK_TOP = 16'h01FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_call,
  input  logic              do_ret,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic              do_irq,
  input  logic              do_iret,
  input  logic              do_sprst,
  input  logic              do_spld,
  input  logic [DATA_W-1:0] ld_val,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] cc_in,
  input  logic [DATA_W-1:0] push_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [SP_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic [SP_W-1:0]   sp,
  output logic [PC_W-1:0]   pc_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] cc_out,
  output logic [DATA_W-1:0] pop_out
);
  localparam logic [SP_W-WIN_W-1:0] HI_BITS = STACK_TOP[SP_W-1:WIN_W];

  logic            wr, rd, p_rst, p_ld;
  dest_e           dest;
  logic [SP_W-1:0] sp_up;

  stk_seq #(.DATA_W(DATA_W), .PC_W(PC_W), .IMASK_BIT(IMASK_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .do_call(do_call), .do_ret(do_ret), .do_push(do_push), .do_pop(do_pop),
    .do_irq(do_irq), .do_iret(do_iret), .do_sprst(do_sprst), .do_spld(do_spld),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in), .push_in(push_in),
    .busy(busy), .wr(wr), .rd(rd), .wdata(mem_wdata), .dest(dest),
    .p_rst(p_rst), .p_ld(p_ld)
  );

  stk_ptr #(.SP_W(SP_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .STACK_TOP(STACK_TOP)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .p_rst(p_rst), .p_ld(p_ld), .p_dec(wr), .p_inc(rd),
    .ld_val(ld_val), .sp(sp), .sp_up(sp_up)
  );

  stk_restore #(.DATA_W(DATA_W), .PC_W(PC_W)) u_rest (
    .clk(clk), .rst_n(rst_n), .rd(rd), .dest(dest), .rdata(mem_rdata),
    .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .cc_out(cc_out),
    .pop_out(pop_out)
  );

  assign mem_we   = wr;
  assign mem_addr = rd ? sp_up : sp;

  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[SP_W-1:WIN_W] == HI_BITS));
  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp[WIN_W-1:0] == $past(mem_addr[WIN_W-1:0]) - 1'b1));
  p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (sp == $past(mem_addr)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
endmodule

// File: tb/tb_stk_ctx_unit.sv
module tb_stk_ctx_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic do_call, do_ret, do_push, do_pop, do_irq, do_iret, do_sprst, do_spld;
  logic [7:0]  ld_val, x_in, a_in, cc_in, push_in, mem_rdata;
  logic [15:0] pc_in;
  logic [15:0] mem_addr, sp, pc_out;
  logic [7:0]  mem_wdata, x_out, a_out, cc_out, pop_out;
  logic        mem_we, busy;
  logic [7:0]  mem [0:511];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stk_ctx_unit dut (
    .clk(clk), .rst_n(rst_n),
    .do_call(do_call), .do_ret(do_ret), .do_push(do_push), .do_pop(do_pop),
    .do_irq(do_irq), .do_iret(do_iret), .do_sprst(do_sprst), .do_spld(do_spld),
    .ld_val(ld_val), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .push_in(push_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy),
    .sp(sp), .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .cc_out(cc_out),
    .pop_out(pop_out)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[8:0]];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_cmds();
    {do_call, do_ret, do_push, do_pop, do_irq, do_iret, do_sprst, do_spld} = '0;
  endtask

  // raise strobe index k for one cycle, then count busy cycles
  task automatic run(input int k, output int nbusy);
    @(negedge clk);
    case (k)
      0: do_call = 1; 1: do_ret = 1; 2: do_push = 1; 3: do_pop = 1;
      4: do_irq = 1;  5: do_iret = 1; 6: do_sprst = 1; default: do_spld = 1;
    endcase
    @(negedge clk);
    clear_cmds();
    nbusy = 0;
    while (busy) begin nbusy++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 reset sp", sp, 16'h01FF);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset we", mem_we, 0);
  endtask

  task automatic t_push_pop();
    int nb;
    run(6, nb);
    push_in = 8'hA7;
    run(2, nb);
    chk("R3 push data", mem[9'h1FF], 8'hA7);
    chk("R3 push sp", sp, 16'h01FE);
    chk("R9 push busy", nb, 1);
    run(3, nb);
    chk("R3 pop data", pop_out, 8'hA7);
    chk("R3 pop sp", sp, 16'h01FF);
    chk("R9 pop busy", nb, 1);
  endtask

  task automatic t_call_ret();
    int nb;
    pc_in = 16'h1234;
    run(0, nb);
    chk("R5 call pcl", mem[9'h1FF], 8'h34);
    chk("R5 call pch", mem[9'h1FE], 8'h12);
    chk("R5 call sp", sp, 16'h01FD);
    chk("R9 call busy", nb, 2);
    pc_in = 16'h0000;
    run(1, nb);
    chk("R5 ret pc", pc_out, 16'h1234);
    chk("R5 ret sp", sp, 16'h01FF);
    chk("R9 ret busy", nb, 2);
  endtask

  task automatic t_irq_iret();
    int nb;
    mem[9'h1FA] = 8'hEE;
    pc_in = 16'hABCD; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h01;
    run(4, nb);
    chk("R6 frame pcl", mem[9'h1FF], 8'hCD);
    chk("R6 frame pch", mem[9'h1FE], 8'hAB);
    chk("R6 frame x", mem[9'h1FD], 8'h11);
    chk("R6 frame a", mem[9'h1FC], 8'h22);
    chk("R7 frame cc mask", mem[9'h1FB], 8'h09);
    chk("R6 frame sp", sp, 16'h01FA);
    chk("R6 no extra byte", mem[9'h1FA], 8'hEE);
    chk("R9 irq busy", nb, 5);
    run(5, nb);
    chk("R7 iret pc", pc_out, 16'hABCD);
    chk("R7 iret x", x_out, 8'h11);
    chk("R7 iret a", a_out, 8'h22);
    chk("R7 iret cc", cc_out, 8'h09);
    chk("R7 iret sp", sp, 16'h01FF);
    chk("R9 iret busy", nb, 5);
    // mask bit comes from the stored byte
    run(4, nb);
    mem[9'h1FB] = 8'h02;
    run(5, nb);
    chk("R7 restored cc without mask", cc_out, 8'h02);
  endtask

  task automatic t_wrap_load();
    int nb;
    ld_val = 8'h00;
    run(7, nb);
    chk("R8 load 00", sp, 16'h0180);
    push_in = 8'h5A;
    run(2, nb);
    chk("R4 push at bottom", mem[9'h180], 8'h5A);
    chk("R4 wrap down", sp, 16'h01FF);
    run(3, nb);
    chk("R4 pop wrap data", pop_out, 8'h5A);
    chk("R4 wrap up", sp, 16'h0180);
    ld_val = 8'h85;
    run(7, nb);
    chk("R8 load 85 forced hi", sp, 16'h0185);
    chk("R2 window hi bits", {16'd0, sp[15:7]}, 32'h3);
    ld_val = 8'hFF;
    run(7, nb);
    chk("R8 load FF", sp, 16'h01FF);
    ld_val = 8'h10;
    run(7, nb);
    run(6, nb);
    chk("R1 pointer reset cmd", sp, 16'h01FF);
  endtask

  task automatic t_ignore_busy();
    int nb;
    run(6, nb);
    mem[9'h1FA] = 8'hEE;
    mem[9'h1F9] = 8'hEE;
    pc_in = 16'h4321; x_in = 8'h33; a_in = 8'h44; cc_in = 8'h00;
    push_in = 8'h77; ld_val = 8'h00;
    @(negedge clk); do_irq = 1;
    @(negedge clk); clear_cmds(); do_push = 1;
    @(negedge clk); clear_cmds(); do_spld = 1;
    @(negedge clk); clear_cmds();
    nb = 0;
    while (busy) begin nb++; @(negedge clk); end
    chk("R10 sp after ignored cmds", sp, 16'h01FA);
    chk("R10 no push write", mem[9'h1FA], 8'hEE);
    chk("R10 no write below", mem[9'h1F9], 8'hEE);
    chk("R10 frame cc intact", mem[9'h1FB], 8'h08);
    chk("R10 frame pcl intact", mem[9'h1FF], 8'h21);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    clear_cmds();
    ld_val = 0; pc_in = 0; x_in = 0; a_in = 0; cc_in = 0; push_in = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_call_ret();
    t_irq_iret();
    t_wrap_load();
    t_ignore_busy();
    done = 1;
    report();
  end
endmodule